// File: doc/BRIEF.md
# Byte-Serial AES-128 Key Schedule

This block stores one 128-bit AES round key and computes the next one a byte at a time, in either direction along the AES-128 key schedule. A 16-byte shift register holds the key. Every update shifts the whole register left by one byte and writes the new byte into the top slot (index 15), which drops the oldest byte from index 0. The byte at index 15 is always visible on `key_byte_out`, so each round key streams out as it is generated and can be fed straight into an AddRoundKey stage. The S-box and the round-constant register are inside the block. The data state, MixColumns and the cipher sequencer are outside it.

The direction is latched from `mode` while `load` is high. In forward mode the block starts from the cipher key and emits round keys 1 to 10. In reverse mode it starts from round key 10 and emits round keys 9 down to 0. The reverse direction uses the same datapath as the forward one. Before each new word the whole key is rotated by eight bytes, so that the two operands of the reverse formula sit where the forward formula expects them. The round constant doubles in GF(2^8) going forward and halves going backward. Its value also tells when ten rounds are done.

The controller has five states:
- KS_IDLE waits for `step`.
- KS_LOAD is held while bytes are shifted in.
- KS_ALIGN applies a one-time 4-byte rotation after a reverse load.
- KS_ROT applies the 8-byte rotation before each reverse word.
- KS_GEN produces four bytes per word.

Transitions:
- `load` moves any state to KS_LOAD.
- When `load` falls, KS_LOAD goes to KS_ALIGN in reverse mode and to KS_IDLE in forward mode.
- KS_ALIGN returns to KS_IDLE after 4 cycles.
- In KS_IDLE, `step` while not done starts a round: KS_GEN in forward mode, KS_ROT in reverse mode.
- KS_ROT goes to KS_GEN after 8 cycles.
- In KS_GEN, after each 4-byte word the state returns to KS_ROT (reverse mode, more words left), stays in KS_GEN (forward mode), or goes to KS_IDLE after the fourth word. Leaving for KS_IDLE also steps the round constant.

Top module: `keysched_serial`

## Requirements
- R1: While `load` is high, each clock appends `key_in` at index 15 and shifts the register left by one byte, so `key_byte_out` shows that byte one cycle later. Sixteen load cycles place key byte 0 (the most significant byte of word 0) at index 0. `mode` is latched during load (0 = forward, 1 = reverse) and is ignored at all other times.
- R2: In forward mode, a `step` accepted in KS_IDLE makes the next 16 clocks each append one byte of the next round key. The order is word 0 byte 0 first and word 3 byte 3 last, where byte 0 is the most significant byte of a word. The round-key values match the standard AES-128 expansion.
- R3: The first byte of each f-transformed word equals the old word byte XOR S(byte 1 of the previous word) XOR the round constant. Bytes 1 to 3 of that word use S(previous word bytes 2, 3, 0) with no constant. The S-box is the standard AES S-box, so S(0x00)=0x63 and S(0x01)=0x7C.
- R4: A forward load sets the round constant to 0x01. Each completed forward round multiplies it by x modulo 0x11B, giving 0x01, 0x02, …, 0x80, 0x1B, 0x36 for rounds 1 to 10.
- R5: In reverse mode each `step` produces the previous round key as four words. Each word takes 8 rotate clocks followed by 4 generate clocks. The words come out in descending index order: word 3 of the round key first, word 0 last.
- R6: A reverse load sets the round constant to 0x36. Each completed reverse round steps it backward, so rounds use 0x36, 0x1B, 0x80, …, 0x01. The tenth reverse round therefore recovers the cipher key.
- R7: `done` is high in KS_IDLE once ten rounds have completed in the latched direction, and low at every other time.
- R8: `step` has no effect while `done` is high or while a round is in progress. `key_byte_out` stays unchanged and no extra round starts.
- R9: After reset, `key_byte_out` is 0x00 and `done` is low.
- R10: After a reverse load, four alignment clocks rotate the key left by four bytes. `key_byte_out` then shows byte 3 of loaded word 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 8 | Key byte appended on each load cycle |
| load | input | 1 | Shift `key_in` into the key register and restart the schedule |
| mode | input | 1 | Direction sampled during load: 0 forward, 1 reverse |
| step | input | 1 | Request the next round key (accepted in KS_IDLE only) |
| key_byte_out | output | 8 | Byte at index 15, the most recently appended byte |
| done | output | 1 | Ten rounds complete in the latched direction |

## Verification
The bench covers the full ten-round schedule in both directions for three keys, including all-zero and all-ones. A wrong S-box input index (for example using index 13 for the fourth byte instead of index 9) would corrupt byte 3 of every f-word. A constant added to more than byte 0 would corrupt bytes 1 to 3. A wrong reverse rotation amount would mix the wrong operand words from the second word on. A backward round-constant step with the wrong reduction would first show up when 0x1B steps back to 0x80. The bench also raises `step` in the middle of a round and after `done`, and toggles `mode` after a load. A design that acted on these inputs would emit extra bytes or change direction.

// File: rtl/keysched_pkg.sv
package keysched_pkg;

    typedef enum logic [2:0] {
        KS_IDLE,
        KS_LOAD,
        KS_ALIGN,
        KS_ROT,
        KS_GEN
    } ks_state_t;

    localparam logic [7:0] RC_FWD_START = 8'h01;
    localparam logic [7:0] RC_REV_START = 8'h36;
    localparam logic [7:0] RC_FWD_END   = 8'h6C;  // one forward step past 0x36
    localparam logic [7:0] RC_REV_END   = 8'h8D;  // one backward step past 0x01

    function automatic logic [7:0] gf_dbl(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic logic [7:0] gf_half(input logic [7:0] a);
        return a[0] ? (((a ^ 8'h1B) >> 1) | 8'h80) : (a >> 1);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

endpackage

// File: rtl/ks_sbox.sv
module ks_sbox
    import keysched_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] inv;

    // Inversion as x^254 by square-and-multiply.
    always_comb begin
        logic [7:0] base;
        logic [7:0] res;
        base = din;
        res  = 8'h01;
        for (int i = 0; i < 8; i++) begin
            if (((8'd254 >> i) & 8'd1) != 8'd0) res = gf_mul(res, base);
            base = gf_mul(base, base);
        end
        inv = res;
    end

    assign dout = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                      ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
endmodule

// File: rtl/ks_rcon.sv
module ks_rcon
    import keysched_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_fwd,
    input  logic       init_rev,
    input  logic       adv,
    input  logic       ret,
    output logic [7:0] rcon
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rcon <= RC_FWD_START;
        else if (init_fwd) rcon <= RC_FWD_START;
        else if (init_rev) rcon <= RC_REV_START;
        else if (adv)      rcon <= gf_dbl(rcon);
        else if (ret)      rcon <= gf_half(rcon);
    end

    // R6
    rcon_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !adv && !init_fwd && !init_rev) |=> (gf_dbl(rcon) == $past(rcon)));
endmodule

// File: rtl/ks_store.sv
module ks_store #(
    parameter int KEY_BYTES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic                      sel_old,
    input  logic                      sel_feed,
    input  logic [7:0]                feed,
    output logic [KEY_BYTES-1:0][7:0] q
);
    logic [7:0]                appended;
    logic [KEY_BYTES-1:0][7:0] q_n;

    assign appended = (sel_old ? q[0] : 8'h00) ^ (sel_feed ? feed : 8'h00);

    for (genvar g = 0; g < KEY_BYTES - 1; g++) begin : g_shift
        assign q_n[g] = q[g+1];
    end
    assign q_n[KEY_BYTES-1] = appended;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= q_n;
    end

    // R5
    wrap_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && sel_old && !sel_feed) |=> (q[KEY_BYTES-1] == $past(q[0])));
endmodule

// File: rtl/keysched_serial.sv
module keysched_serial
    import keysched_pkg::*;
#(
    parameter int KEY_BYTES  = 16,
    parameter int WORD_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] key_in,
    input  logic       load,
    input  logic       mode,
    input  logic       step,
    output logic [7:0] key_byte_out,
    output logic       done
);
    localparam int WORDS     = KEY_BYTES / WORD_BYTES;
    localparam int ROT_LEN   = 2 * WORD_BYTES;
    localparam int ALIGN_LEN = WORD_BYTES;
    localparam int CW        = $clog2(ROT_LEN);
    localparam int WW        = $clog2(WORDS);
    localparam int COL_IDX   = KEY_BYTES - WORD_BYTES;
    localparam int SB_IDX    = COL_IDX + 1;
    localparam int SB_LAST   = SB_IDX - WORD_BYTES;

    ks_state_t state_q, state_n;
    logic [CW-1:0] bcnt_q, bcnt_n;
    logic [WW-1:0] wcnt_q, wcnt_n;
    logic          rev_q;
    logic          round_end;
    logic          done_w;

    logic [KEY_BYTES-1:0][7:0] kq;
    logic [7:0] rcon;
    logic [7:0] sb_in, sb_out, feed;
    logic       shift_en, sel_old, sel_feed, f_word;

    ks_sbox u_sbox (.din(sb_in), .dout(sb_out));

    ks_rcon u_rcon (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_fwd(load && !mode),
        .init_rev(load && mode),
        .adv     (round_end && !rev_q),
        .ret     (round_end && rev_q),
        .rcon    (rcon)
    );

    ks_store #(.KEY_BYTES(KEY_BYTES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .sel_old (sel_old),
        .sel_feed(sel_feed),
        .feed    (feed),
        .q       (kq)
    );

    assign done_w = (state_q == KS_IDLE) && (rcon == (rev_q ? RC_REV_END : RC_FWD_END));

    // Next-state logic
    always_comb begin
        state_n   = state_q;
        bcnt_n    = bcnt_q;
        wcnt_n    = wcnt_q;
        round_end = 1'b0;
        if (load) begin
            state_n = KS_LOAD;
            bcnt_n  = '0;
            wcnt_n  = '0;
        end else begin
            unique case (state_q)
                KS_IDLE: begin
                    if (step && !done_w) begin
                        state_n = rev_q ? KS_ROT : KS_GEN;
                        bcnt_n  = '0;
                        wcnt_n  = '0;
                    end
                end
                KS_LOAD: begin
                    state_n = rev_q ? KS_ALIGN : KS_IDLE;
                    bcnt_n  = '0;
                end
                KS_ALIGN: begin
                    bcnt_n = bcnt_q + 1'b1;
                    if (bcnt_q == CW'(ALIGN_LEN - 1)) begin
                        state_n = KS_IDLE;
                        bcnt_n  = '0;
                    end
                end
                KS_ROT: begin
                    bcnt_n = bcnt_q + 1'b1;
                    if (bcnt_q == CW'(ROT_LEN - 1)) begin
                        state_n = KS_GEN;
                        bcnt_n  = '0;
                    end
                end
                KS_GEN: begin
                    bcnt_n = bcnt_q + 1'b1;
                    if (bcnt_q == CW'(WORD_BYTES - 1)) begin
                        bcnt_n = '0;
                        wcnt_n = wcnt_q + 1'b1;
                        if (wcnt_q == WW'(WORDS - 1)) begin
                            state_n   = KS_IDLE;
                            round_end = 1'b1;
                        end else if (rev_q) begin
                            state_n = KS_ROT;
                        end
                    end
                end
                default: state_n = KS_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
            bcnt_q  <= '0;
            wcnt_q  <= '0;
            rev_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            bcnt_q  <= bcnt_n;
            wcnt_q  <= wcnt_n;
            if (load) rev_q <= mode;
        end
    end

    // Outputs and datapath controls
    always_comb begin
        f_word   = rev_q ? (wcnt_q == WW'(WORDS - 1)) : (wcnt_q == '0);
        sb_in    = (bcnt_q == CW'(WORD_BYTES - 1)) ? kq[SB_LAST] : kq[SB_IDX];
        shift_en = load || (state_q == KS_ALIGN) || (state_q == KS_ROT) || (state_q == KS_GEN);
        sel_feed = load || (state_q == KS_GEN);
        sel_old  = !load && shift_en;
        if (load)
            feed = key_in;
        else if (f_word)
            feed = sb_out ^ ((bcnt_q == '0) ? rcon : 8'h00);
        else
            feed = kq[COL_IDX];
        key_byte_out = kq[KEY_BYTES-1];
        done         = done_w;
    end

    // R1
    load_append_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (key_byte_out == $past(key_in)));

    // R8
    step_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && step && !load) |=> (done && $stable(key_byte_out)));

    // R6
    rcon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == KS_ROT || state_q == KS_ALIGN) && !load) |=> $stable(rcon));

    // R7
    done_after_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(state_q) == KS_GEN));
endmodule

// File: tb/keysched_serial_tb_top.sv
module keysched_serial_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_in = 8'h00;
    logic       load = 1'b0;
    logic       mode = 1'b0;
    logic       step = 1'b0;
    logic [7:0] key_byte_out;
    logic       done;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  sbt [0:255];
    logic [31:0] w   [0:43];

    always #2 clk = ~clk;

    keysched_serial dut_i (
        .clk(clk), .rst_n(rst_n), .key_in(key_in), .load(load),
        .mode(mode), .step(step), .key_byte_out(key_byte_out), .done(done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = 16'h0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] bsel(input logic [31:0] wd, input int j);
        return wd[31-8*j -: 8];
    endfunction

    task automatic build_sbox();
        for (int x = 0; x < 256; x++) begin
            logic [7:0] iv;
            logic [7:0] r;
            iv = 8'h00;
            for (int y = 1; y < 256; y++) if (tmul(8'(x), 8'(y)) == 8'h01) iv = 8'(y);
            for (int i = 0; i < 8; i++)
                r[i] = iv[i] ^ iv[(i+4)%8] ^ iv[(i+5)%8] ^ iv[(i+6)%8] ^ iv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
            sbt[x] = r;
        end
    endtask

    task automatic expand(input logic [127:0] key);
        logic [7:0] rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            logic [31:0] t;
            t = w[i-1];
            if (i % 4 == 0) begin
                t = {sbt[t[23:16]], sbt[t[15:8]], sbt[t[7:0]], sbt[t[31:24]]} ^ {rc, 24'h0};
                rc = (rc[7]) ? ((rc << 1) ^ 8'h1B) : (rc << 1);
            end
            w[i] = w[i-4] ^ t;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 reset out", 32'(key_byte_out), 32'h00);
        chk("R9 reset done", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_sbox_sanity();
        chk("R3 S(00)", 32'(sbt[8'h00]), 32'h63);
        chk("R3 S(01)", 32'(sbt[8'h01]), 32'h7C);
    endtask

    task automatic t_load(input logic [31:0] w0, w1, w2, w3, input logic m);
        logic [127:0] k;
        k = {w0, w1, w2, w3};
        @(negedge clk);
        load = 1'b1;
        mode = m;
        for (int b = 0; b < 16; b++) begin
            key_in = k[127-8*b -: 8];
            @(negedge clk);
            chk("R1 load append", 32'(key_byte_out), 32'(k[127-8*b -: 8]));
        end
        load = 1'b0;
        mode = ~m;  // R1: ignored outside load
    endtask

    task automatic t_forward(input logic [127:0] key, input bit inject);
        expand(key);
        t_load(w[0], w[1], w[2], w[3], 1'b0);
        repeat (2) @(negedge clk);
        for (int r = 1; r <= 10; r++) begin
            chk("R7 done low fwd", 32'(done), 32'h0);
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                chk((k == 0) ? "R4 R3 fwd rcon byte" : "R2 fwd byte",
                    32'(key_byte_out), 32'(bsel(w[4*r + k/4], k % 4)));
                step = (inject && k == 7);  // R8: mid-round step
            end
            step = 1'b0;
            if (inject && r == 1) begin
                logic [7:0] hold;
                hold = key_byte_out;
                repeat (4) @(negedge clk);
                chk("R8 no extra round", 32'(key_byte_out), 32'(hold));
            end
        end
        chk("R7 done fwd", 32'(done), 32'h1);
    endtask

    task automatic t_after_done();
        logic [7:0] hold;
        hold = key_byte_out;
        step = 1'b1;
        repeat (6) @(negedge clk);
        step = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 step while done out", 32'(key_byte_out), 32'(hold));
        chk("R8 step while done flag", 32'(done), 32'h1);
    endtask

    task automatic t_reverse(input logic [127:0] key);
        expand(key);
        t_load(w[40], w[41], w[42], w[43], 1'b1);
        repeat (5) @(negedge clk);
        chk("R10 align", 32'(key_byte_out), 32'(bsel(w[40], 3)));
        for (int r = 1; r <= 10; r++) begin
            int base;
            base = 40 - 4*r;
            chk("R7 done low rev", 32'(done), 32'h0);
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
            for (int wd = 0; wd < 4; wd++) begin
                repeat (8) @(negedge clk);
                for (int b = 0; b < 4; b++) begin
                    @(negedge clk);
                    chk((wd == 3 && b == 0) ? "R6 rev rcon byte" : "R5 rev byte",
                        32'(key_byte_out), 32'(bsel(w[base + 3 - wd], b)));
                end
            end
        end
        chk("R7 done rev", 32'(done), 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        build_sbox();
        t_sbox_sanity();
        expand(128'h2b7e151628aed2a6abf7158809cf4f3c);
        chk("R2 model w43", w[43], 32'hb6630ca6);
        t_reset();
        t_forward(128'h2b7e151628aed2a6abf7158809cf4f3c, 1'b1);
        t_after_done();
        t_reverse(128'h2b7e151628aed2a6abf7158809cf4f3c);
        t_after_done();
        t_forward(128'h0, 1'b0);
        t_reverse(128'hffffffffffffffffffffffffffffffff);
        t_reverse(128'h0);
        t_forward(128'hffffffffffffffffffffffffffffffff, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule